// File: doc/BRIEF.md
# Multi-channel ADC serial scan controller

This block is the host side of a serial link to a four-input, 8-bit sampling converter. It owns the converter's chip-select, its serial clock and its command line, and it reads the converter's result line. While `scan_en` is high it keeps issuing frames. Each frame holds one 16-clock conversion, or `CONV_PER_FRAME` back-to-back conversions when `multi_conv` is high. The channels it visits come from a mask of enabled inputs, taken in ascending order with wrap-around.

The converter has a one-conversion lag. The channel code sent during a conversion picks the input for the conversion after it. The controller therefore keeps two registers: the channel being requested now and the channel being converted now. It tags each result with the channel that was requested one conversion earlier. After reset the first result always belongs to input 1 (tag 0).

The state machine has five states: `S_IDLE` (select high, clock high), `S_SETUP` (select low, clock still high for one half period), `S_LOW` and `S_HIGH` (the two halves of each serial clock), and `S_GAP` (select high again for one half period). The transitions are:
- IDLE→SETUP when `scan_en` is high.
- SETUP→LOW on a half-period tick.
- LOW→HIGH on a tick. This is the rising edge, where the result bit is sampled.
- HIGH→LOW on a tick, either inside a conversion or at clock 16 when more conversions remain in the frame.
- HIGH→GAP on a tick at clock 16 of the last conversion.
- GAP→IDLE on a tick.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is held and afterwards with `scan_en` low, `adc_cs_n` is 1, `adc_sclk` is 1, `adc_mosi` is 0 and `sample_vld` is 0.
- R2: A frame starts when `adc_cs_n` falls. The first falling edge of `adc_sclk` comes at least `HALF_DIV` system clocks later. When `adc_cs_n` rises again the frame has had exactly 16 rising `adc_sclk` edges if `multi_conv` is 0, and 16×`CONV_PER_FRAME` if it is 1.
- R3: In each conversion an 8-bit command goes out MSB first, one bit valid on each of the first 8 rising edges. Command bits 4:3 carry the requested channel code (0 = input 1, 1 = input 2, 2 = input 3, 3 = input 4). Bits 7:5 and 2:0 are always 0. `adc_mosi` is 0 while `adc_cs_n` is high.
- R4: The requested channels step through the inputs whose `chan_mask` bit i is 1 (bit i = channel code i), in ascending order with wrap-around. After reset the first request is the lowest enabled channel. A mask of 0 enables all four channels.
- R5: The first result after reset is tagged 0. Every later result is tagged with the channel code that was requested during the conversion before it.
- R6: `sample_data` holds the `adc_miso` bits sampled on rising edges 5 to 12 of the conversion, MSB first. Bits on the other edges are ignored.
- R7: `sample_vld` pulses for exactly one system clock per conversion. `sample_data` and `sample_ch` change only together with that pulse.
- R8: `adc_sclk` is high whenever `adc_cs_n` is high. Inside a frame, rising edges are spaced 2×`HALF_DIV` system clocks apart, including across conversion boundaries.
- R9: When `scan_en` falls, the frame in progress completes all its conversions and no new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Keep issuing frames while high |
| multi_conv | input | 1 | 1: `CONV_PER_FRAME` conversions per frame; 0: one |
| chan_mask | input | 4 | Enabled channels, bit i = channel code i; 0 means all |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Serial clock, idle high |
| adc_mosi | output | 1 | Command bit to converter |
| adc_miso | input | 1 | Result bit from converter |
| sample_data | output | 8 | Last result |
| sample_ch | output | 2 | Channel code the result belongs to |
| sample_vld | output | 1 | One-cycle strobe for a new result |

## Verification
The bench contains a behavioural converter that applies the one-conversion lag on its own. Every result returned by this converter encodes the channel it actually converted and a running index. A controller that tagged results with the current request instead of the previous one would show a tag mismatch from the second result onward. One that shifted the result window by a clock would return a visibly rotated byte.

Sparse masks (two channels, one channel) and the all-zero mask are tested after reset. These expose a wrong starting channel or a rotation that stalls or visits disabled inputs. Multi-conversion frames are checked for their total edge count, for the clock spacing across the 16→1 boundary, and for the command being reloaded on that boundary.

Dropping `scan_en` mid-frame checks that the frame is neither truncated, which would give an edge count that is not a multiple of 16, nor followed by a stray new frame.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NUM_CH  = 4;
    localparam int CH_W    = 2;
    localparam int DATA_W  = 8;
    localparam int CMD_W   = 8;
    localparam int ADDR_LSB = 3;   // channel field position in the command
    localparam int CONV_CLKS = 16;
    localparam int CAP_FIRST = 5;  // first rising edge carrying a result bit
    localparam int CAP_LAST  = CAP_FIRST + DATA_W - 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_LOW,
        S_HIGH,
        S_GAP
    } scan_state_t;

    // Next enabled channel after cur, ascending with wrap; empty mask = all.
    function automatic logic [CH_W-1:0] next_chan(input logic [CH_W-1:0] cur,
                                                   input logic [NUM_CH-1:0] mask);
        logic [NUM_CH-1:0] eff;
        logic [CH_W-1:0]   res;
        logic [CH_W-1:0]   cand;
        logic              found;
        eff   = (mask == '0) ? '1 : mask;
        res   = cur;
        found = 1'b0;
        for (int i = 1; i <= NUM_CH; i++) begin
            cand = CH_W'((int'(cur) + i) % NUM_CH);
            if (!found && eff[cand]) begin
                res   = cand;
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [NUM_CH-1:0] chan_mask,
    output logic [CH_W-1:0]   cur_ch,
    output logic [CH_W-1:0]   req_ch
);
    logic first;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch <= '0;
            req_ch <= CH_W'(NUM_CH - 1);
            first  <= 1'b1;
        end else if (adv) begin
            if (!first) begin
                cur_ch <= req_ch;
            end
            req_ch <= next_chan(req_ch, chan_mask);
            first  <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_scan_rx.sv
module adc_scan_rx
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              done,
    input  logic              miso,
    input  logic [CH_W-1:0]   tag_in,
    output logic [DATA_W-1:0] sample_data,
    output logic [CH_W-1:0]   sample_ch,
    output logic              sample_vld
);
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh          <= '0;
            sample_data <= '0;
            sample_ch   <= '0;
            sample_vld  <= 1'b0;
        end else begin
            sample_vld <= 1'b0;
            if (shift_en) begin
                sh <= {sh[DATA_W-2:0], miso};
                if (done) begin
                    sample_data <= {sh[DATA_W-2:0], miso};
                    sample_ch   <= tag_in;
                    sample_vld  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int HALF_DIV       = 4,
    parameter int CONV_PER_FRAME = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              multi_conv,
    input  logic [NUM_CH-1:0] chan_mask,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_mosi,
    input  logic              adc_miso,
    output logic [DATA_W-1:0] sample_data,
    output logic [CH_W-1:0]   sample_ch,
    output logic              sample_vld
);
    localparam int CNW = $clog2(CONV_PER_FRAME + 1);
    localparam int KW  = $clog2(CONV_CLKS + 1);

    scan_state_t      state, state_d;
    logic [KW-1:0]    clk_no;
    logic [CNW-1:0]   conv_no;
    logic [CNW-1:0]   last_conv;
    logic [KW-1:0]    n_next;
    logic             tick, adv, rise, capture, done;
    logic [CH_W-1:0]  cur_ch, req_ch;
    logic [CMD_W-1:0] cmd;

    assign last_conv = multi_conv ? CNW'(CONV_PER_FRAME - 1) : '0;
    assign n_next    = (clk_no == KW'(CONV_CLKS)) ? KW'(1) : clk_no + 1'b1;
    assign rise      = (state == S_LOW) && tick;
    assign capture   = rise && (clk_no >= KW'(CAP_FIRST)) && (clk_no <= KW'(CAP_LAST));
    assign done      = rise && (clk_no == KW'(CAP_LAST));

    always_comb begin
        cmd = '0;
        cmd[ADDR_LSB +: CH_W] = req_ch;
    end

    adc_scan_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != S_IDLE),
        .tick (tick)
    );

    adc_scan_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .chan_mask(chan_mask),
        .cur_ch   (cur_ch),
        .req_ch   (req_ch)
    );

    adc_scan_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (capture),
        .done       (done),
        .miso       (adc_miso),
        .tag_in     (cur_ch),
        .sample_data(sample_data),
        .sample_ch  (sample_ch),
        .sample_vld (sample_vld)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        adv     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (scan_en) begin
                    state_d = S_SETUP;
                    adv     = 1'b1;
                end
            end
            S_SETUP: if (tick) state_d = S_LOW;
            S_LOW:   if (tick) state_d = S_HIGH;
            S_HIGH: begin
                if (tick) begin
                    if (clk_no != KW'(CONV_CLKS)) begin
                        state_d = S_LOW;
                    end else if (conv_no == last_conv) begin
                        state_d = S_GAP;
                    end else begin
                        state_d = S_LOW;
                        adv     = 1'b1;
                    end
                end
            end
            S_GAP:   if (tick) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            clk_no  <= '0;
            conv_no <= '0;
        end else begin
            state <= state_d;
            if (state == S_IDLE) begin
                clk_no  <= '0;
                conv_no <= '0;
            end else begin
                if (state_d == S_LOW && state != S_LOW) clk_no <= n_next;
                if (adv) conv_no <= conv_no + 1'b1;
            end
        end
    end

    // registered pin outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_cs_n <= 1'b1;
            adc_sclk <= 1'b1;
            adc_mosi <= 1'b0;
        end else begin
            adc_cs_n <= (state_d == S_IDLE) || (state_d == S_GAP);
            adc_sclk <= (state_d != S_LOW);
            if (state_d == S_IDLE || state_d == S_GAP) begin
                adc_mosi <= 1'b0;
            end else if (state_d == S_LOW && state != S_LOW) begin
                adc_mosi <= (n_next <= KW'(CMD_W)) ? cmd[3'(KW'(CMD_W) - n_next)] : 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scan_en,
    input logic              adc_cs_n,
    input logic              adc_sclk,
    input logic              adc_mosi,
    input logic [DATA_W-1:0] sample_data,
    input logic [CH_W-1:0]   sample_ch,
    input logic              sample_vld
);
    p_idle_sclk_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    p_mosi_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_mosi);

    p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

    p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> ($stable(sample_data) && $stable(sample_ch)));

    p_vld_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> !adc_cs_n);

    p_start_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> $past(scan_en));
endmodule

bind adc_scan_ctrl adc_scan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .adc_cs_n   (adc_cs_n),
    .adc_sclk   (adc_sclk),
    .adc_mosi   (adc_mosi),
    .sample_data(sample_data),
    .sample_ch  (sample_ch),
    .sample_vld (sample_vld)
);

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;
    localparam int HALF = 4;
    localparam int CPF  = 4;
    localparam int MAXN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_en = 1'b0;
    logic multi_conv = 1'b0;
    logic [3:0] chan_mask = 4'hF;
    logic adc_cs_n, adc_sclk, adc_mosi;
    logic adc_miso = 1'b0;
    logic [7:0] sample_data;
    logic [1:0] sample_ch;
    logic sample_vld;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    adc_scan_ctrl #(.HALF_DIV(HALF), .CONV_PER_FRAME(CPF)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .multi_conv(multi_conv),
        .chan_mask(chan_mask), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_mosi(adc_mosi), .adc_miso(adc_miso), .sample_data(sample_data),
        .sample_ch(sample_ch), .sample_vld(sample_vld)
    );

    // behavioural converter: one-conversion lag on the channel code
    logic p_cs, p_sclk;
    int rc, fc, ng, ncmd, frames, last_edges, bad_frames, idle_bad, bad_cmd;
    longint t_cs, t_rise, min_setup, min_per, max_per;
    logic [7:0] cmd_sh, cur_data;
    logic [1:0] conv_ch;
    logic [1:0] grp_ch [MAXN];
    logic [7:0] grp_data [MAXN];
    logic [1:0] cmd_ch [MAXN];

    always @(adc_sclk or adc_cs_n or rst_n) begin
        if (!rst_n) begin
            p_cs = 1'b1; p_sclk = 1'b1; rc = 0; fc = 0; ng = 0; ncmd = 0;
            frames = 0; last_edges = 0; bad_frames = 0; idle_bad = 0; bad_cmd = 0;
            t_cs = 0; t_rise = 0; min_setup = 1000000; min_per = 1000000; max_per = 0;
            cmd_sh = 8'h00; conv_ch = 2'd0; cur_data = 8'h00; adc_miso = 1'b0;
        end else begin
            if (adc_cs_n !== p_cs) begin
                if (!adc_cs_n) begin
                    t_cs = $time; rc = 0; fc = 0;
                end else begin
                    frames++; last_edges = rc;
                    if (rc % 16 != 0) bad_frames++;
                    if (!adc_sclk) idle_bad++;
                end
            end
            if (adc_sclk !== p_sclk) begin
                if (adc_cs_n) begin
                    idle_bad++;
                end else if (!adc_sclk) begin
                    if (fc == 0 && ($time - t_cs) < min_setup) min_setup = $time - t_cs;
                    fc++;
                    if (((fc - 1) % 16 + 1) >= 5 && ((fc - 1) % 16 + 1) <= 12)
                        adc_miso = cur_data[12 - ((fc - 1) % 16 + 1)];
                    else
                        adc_miso = 1'b0;
                end else begin
                    if (rc > 0) begin
                        if ($time - t_rise < min_per) min_per = $time - t_rise;
                        if ($time - t_rise > max_per) max_per = $time - t_rise;
                    end
                    t_rise = $time;
                    rc++;
                    if (((rc - 1) % 16 + 1) <= 8) cmd_sh = {cmd_sh[6:0], adc_mosi};
                    if (((rc - 1) % 16 + 1) == 8) begin
                        if ((cmd_sh & 8'hE7) != 8'h00) bad_cmd++;
                        if (ncmd < MAXN) cmd_ch[ncmd] = cmd_sh[4:3];
                        ncmd++;
                    end
                    if (((rc - 1) % 16 + 1) == 16) begin
                        if (ng < MAXN) begin
                            grp_ch[ng] = conv_ch;
                            grp_data[ng] = cur_data;
                        end
                        ng++;
                        conv_ch = cmd_sh[4:3];
                        cur_data = {conv_ch, 6'(ng * 5 + 3)};
                    end
                end
            end
            p_cs = adc_cs_n; p_sclk = adc_sclk;
        end
    end

    // result collector
    int res_cnt, dbl;
    logic prev_vld;
    logic [1:0] res_ch [MAXN];
    logic [7:0] res_data [MAXN];
    always @(negedge clk) begin
        if (!rst_n) begin
            res_cnt = 0; dbl = 0; prev_vld = 1'b0;
        end else begin
            if (sample_vld) begin
                if (prev_vld) dbl++;
                if (res_cnt < MAXN) begin
                    res_ch[res_cnt] = sample_ch;
                    res_data[res_cnt] = sample_data;
                end
                res_cnt++;
            end
            prev_vld = sample_vld;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] nxt(input logic [1:0] c, input logic [3:0] m);
        logic [3:0] e;
        logic [1:0] r;
        e = (m == 4'h0) ? 4'hF : m;
        r = c;
        for (int i = 4; i >= 1; i--) begin
            if (e[2'(c + 2'(i))]) r = 2'(c + 2'(i));
        end
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; scan_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1: outputs at rest during and after reset
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset", adc_cs_n == 1'b1, adc_cs_n, 1);
        check("R1 sclk in reset", adc_sclk == 1'b1, adc_sclk, 1);
        check("R1 vld in reset", sample_vld == 1'b0, sample_vld, 0);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        check("R1 cs_n idle", adc_cs_n == 1'b1, adc_cs_n, 1);
        check("R1 mosi idle", adc_mosi == 1'b0, adc_mosi, 0);
        check("R1 no frame", frames == 0, frames, 0);
    endtask

    task automatic t_scan(input string name, input logic [3:0] m, input logic mc, input int n);
        logic [1:0] exp [MAXN];
        logic [1:0] q;
        int snap_res, snap_fr;
        do_reset();
        chan_mask = m; multi_conv = mc;
        exp[0] = 2'd0;
        q = nxt(2'd3, m);
        for (int k = 1; k < MAXN; k++) begin
            exp[k] = q;
            q = nxt(q, m);
        end
        scan_en = 1'b1;
        while (res_cnt < n) @(negedge clk);
        scan_en = 1'b0;
        repeat (CPF * 40 * HALF + 50) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            check({name, " R5 tag order"}, res_ch[k] == exp[k], res_ch[k], exp[k]);
            check({name, " R5 tag vs converted"}, res_ch[k] == grp_ch[k], res_ch[k], grp_ch[k]);
            check({name, " R6 data"}, res_data[k] == grp_data[k], res_data[k], grp_data[k]);
        end
        for (int k = 0; k < n - 1; k++)
            check({name, " R4 request order"}, cmd_ch[k] == exp[k + 1], cmd_ch[k], exp[k + 1]);
        check({name, " R3 zero don't-care bits"}, bad_cmd == 0, bad_cmd, 0);
        check({name, " R7 one result per conversion"}, res_cnt == ng, res_cnt, ng);
        check({name, " R7 single-cycle strobe"}, dbl == 0, dbl, 0);
        check({name, " R2 edges per frame"}, last_edges == (mc ? 16 * CPF : 16),
              last_edges, mc ? 16 * CPF : 16);
        check({name, " R2 whole frames"}, bad_frames == 0, bad_frames, 0);
        check({name, " R2 setup time"}, min_setup >= HALF * 10, min_setup, HALF * 10);
        check({name, " R8 min period"}, min_per == 2 * HALF * 10, min_per, 2 * HALF * 10);
        check({name, " R8 max period"}, max_per == 2 * HALF * 10, max_per, 2 * HALF * 10);
        check({name, " R8 idle high"}, idle_bad == 0, idle_bad, 0);
        check({name, " R9 frame finished"}, adc_cs_n == 1'b1, adc_cs_n, 1);
        snap_res = res_cnt; snap_fr = frames;
        repeat (300) @(negedge clk);
        check({name, " R9 no new frame"}, frames == snap_fr, frames, snap_fr);
        check({name, " R9 no new result"}, res_cnt == snap_res, res_cnt, snap_res);
    endtask

    initial begin
        t_reset();
        t_scan("all single", 4'hF, 1'b0, 9);
        t_scan("odd pair single", 4'b1010, 1'b0, 7);
        t_scan("lone ch2 multi", 4'b0100, 1'b1, 6);
        t_scan("empty mask multi", 4'b0000, 1'b1, 10);
        t_scan("ch0+ch3 multi", 4'b1001, 1'b1, 9);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule